// File: doc/BRIEF.md
# PPS-Synchronized Timekeeper

The block keeps a 64-bit tick count that advances by one on every clock cycle. Software reaches it through a small 32-bit register port. There it can read the running time, stage a new time value and commit it. The commit takes effect either at once or at the next rising edge of a pulse-per-second input. Every PPS rising edge also copies the running count into a snapshot register. Software can then relate the count to the second boundary after the fact.

Because the time is wider than the bus, it is split into two words. Reading the low word of the running time freezes the matching high word in a shadow register. A following high-word read therefore returns a value that is consistent with the low word, even if a carry crossed the word boundary between the two reads. A 64-bit tick-period value is stored and read back for software. The counter does not use it.

Top module: `pps_timekeeper`

## Requirements
- R1: A synchronous, active-high reset clears the running time, the event time, the PPS snapshot and any armed load. Immediately after reset these read as zero: the running time reads the number of cycles elapsed since reset was released, and control word bit 1 reads 0.
- R2: The running time increases by exactly one every clock cycle in which no load occurs. The carry passes from the low word into the high word.
- R3: Writing the control word (byte offset 0x10) with bit 0 set loads the event time into the running time on that clock edge. Counting continues from that value.
- R4: Writing the control word with only bit 1 set arms a load. While the load is armed, control bit 1 reads 1. At the next PPS rising edge the event time is loaded and the arm clears. Later PPS edges load nothing.
- R5: On every PPS rising edge, the running-time value present just before that edge is latched into the snapshot words (low at 0x14, high at 0x18).
- R6: A read of the running-time low word (0x00) returns the low 32 bits. In the same cycle it latches the high 32 bits. A read of the high word (0x04) returns the latched value.
- R7: The tick-period words (low at 0x1C, high at 0x20) read back the value last written.
- R8: A control write with both bits 0 and 1 set performs the immediate load and discards the arm. Control bit 1 reads 0, and the next PPS edge does not reload.
- R9: The event words (low at 0x08, high at 0x0C) read back the value last written.
- R10: The PPS input passes through a two-flop synchronizer and is edge detected. A pulse held high for many cycles produces exactly one snapshot. The snapshot is taken two cycles after the input is first sampled high. The falling edge has no effect.
- R11: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| reg_addr | input | AW | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench targets four corner cases.

The first is a low-word value of all ones, read just before the carry into the high word. A design without the shadow latch would return a high word one too large.

The second is PPS timing. The bench predicts the snapshot arithmetically from the synchronizer latency. A design with the wrong flop count would snapshot a neighbouring count. A design that is level-sensitive would keep overwriting the snapshot while the pulse is held.

The third is the armed load, checked across two PPS edges. A design that never clears the arm would reload the event time on the second edge.

The fourth is a control value of three. A design that lets the arm survive that write would jump back to the event time at the following PPS edge.

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pps_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  input  logic          reg_rd,
  output logic [31:0]   reg_rdata
);
  localparam int WIW = AW - 2;
  localparam logic [WIW-1:0] W_NOW_LO = WIW'(0);
  localparam logic [WIW-1:0] W_NOW_HI = WIW'(1);
  localparam logic [WIW-1:0] W_EV_LO  = WIW'(2);
  localparam logic [WIW-1:0] W_EV_HI  = WIW'(3);
  localparam logic [WIW-1:0] W_CTRL   = WIW'(4);
  localparam logic [WIW-1:0] W_SN_LO  = WIW'(5);
  localparam logic [WIW-1:0] W_SN_HI  = WIW'(6);
  localparam logic [WIW-1:0] W_PER_LO = WIW'(7);
  localparam logic [WIW-1:0] W_PER_HI = WIW'(8);

  logic [63:0] tnow, tev, tsnap, tper;
  logic [31:0] hi_shadow;
  logic        armed;
  logic [2:0]  pps_sr;

  wire [WIW-1:0] widx     = reg_addr[AW-1:2];
  wire           pps_edge = pps_sr[1] & ~pps_sr[2];
  wire           ctrl_wr  = reg_wr && (widx == W_CTRL);
  wire           load_now = ctrl_wr && reg_wdata[0];
  wire           arm_wr   = ctrl_wr && reg_wdata[1] && !reg_wdata[0];
  wire           load_pps = pps_edge && armed && !load_now;

  always_ff @(posedge clk) begin
    if (rst) pps_sr <= '0;
    else     pps_sr <= {pps_sr[1:0], pps_in};
  end

  always_ff @(posedge clk) begin
    if (rst)           tnow <= '0;
    else if (load_now) tnow <= tev;
    else if (load_pps) tnow <= tev;
    else               tnow <= tnow + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (load_now) armed <= 1'b0;
    else if (arm_wr)   armed <= 1'b1;
    else if (pps_edge) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           tsnap <= '0;
    else if (pps_edge) tsnap <= tnow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tev  <= '0;
      tper <= '0;
    end else if (reg_wr) begin
      case (widx)
        W_EV_LO:  tev[31:0]   <= reg_wdata;
        W_EV_HI:  tev[63:32]  <= reg_wdata;
        W_PER_LO: tper[31:0]  <= reg_wdata;
        W_PER_HI: tper[63:32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      hi_shadow <= '0;
    end else if (reg_rd) begin
      case (widx)
        W_NOW_LO: begin
          reg_rdata <= tnow[31:0];
          hi_shadow <= tnow[63:32];
        end
        W_NOW_HI: reg_rdata <= hi_shadow;
        W_EV_LO:  reg_rdata <= tev[31:0];
        W_EV_HI:  reg_rdata <= tev[63:32];
        W_CTRL:   reg_rdata <= {30'd0, armed, 1'b0};
        W_SN_LO:  reg_rdata <= tsnap[31:0];
        W_SN_HI:  reg_rdata <= tsnap[63:32];
        W_PER_LO: reg_rdata <= tper[31:0];
        W_PER_HI: reg_rdata <= tper[63:32];
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load_now && !load_pps) |=> (tnow == $past(tnow) + 64'd1)); // R2
  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (tnow == $past(tev) && !armed)); // R3
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pps_edge && armed && !ctrl_wr) |=> !armed); // R4
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    pps_edge |=> (tsnap == $past(tnow))); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pps_edge |=> $stable(tsnap)); // R10
  AST_BOTH_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[1:0] == 2'b11) |=> !armed); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R11
endmodule

// File: tb/pps_timekeeper_bench.sv
module pps_timekeeper_bench;
  logic        clk = 0, rst = 1, pps_in = 0, reg_wr = 0, reg_rd = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int total = 0, bad = 0, cyc = 0, last_t = 0, tz = 0, tp = 0, bc = 0;
  logic [63:0] base = '0;
  logic [31:0] r;
  bit done = 0;

  pps_timekeeper u_pps_timekeeper (.clk(clk), .rst(rst), .pps_in(pps_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [63:0] exp_at(int t);
    return base + 64'(t - bc - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 last_t = cyc;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(posedge clk); #1 last_t = cyc;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(int hold);
    @(negedge clk); pps_in = 1;
    @(posedge clk); #1 tp = cyc;
    repeat (hold) @(negedge clk);
    pps_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_time(logic [63:0] e, logic [31:0] c);
    wr(6'h08, e[31:0]); wr(6'h0C, e[63:32]); wr(6'h10, c);
  endtask

  task automatic chk_now(string tag);
    logic [63:0] e;
    rd(6'h00, r); e = exp_at(last_t); chk(tag, r, e[31:0]);
    rd(6'h04, r); chk(tag, r, e[63:32]);
  endtask

  task automatic chk_snap(string tag, logic [63:0] e);
    rd(6'h14, r); chk(tag, r, e[31:0]);
    rd(6'h18, r); chk(tag, r, e[63:32]);
  endtask

  initial begin
    logic [63:0] sn;
    repeat (3) @(posedge clk);
    #1 tz = cyc;
    @(negedge clk); rst = 0;
    base = '0; bc = tz;
    // R1 reset state
    rd(6'h14, r); chk("R1 snap lo", r, 0);
    rd(6'h18, r); chk("R1 snap hi", r, 0);
    rd(6'h08, r); chk("R1 event lo", r, 0);
    rd(6'h0C, r); chk("R1 event hi", r, 0);
    rd(6'h10, r); chk("R1 ctrl", r, 0);
    chk_now("R1 R2 time since reset");
    // R11 unmapped and hold
    rd(6'h24, r); chk("R11 unmapped", r, 0);
    rd(6'h3C, r); chk("R11 unmapped top", r, 0);
    // R7 / R9 readback
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p = 32'h1234_5678 ^ (32'h1111_1111 * k);
      wr(6'h1C, p); wr(6'h20, ~p);
      wr(6'h08, p + 7); wr(6'h0C, p - 3);
      rd(6'h1C, r); chk("R7 period lo", r, p);
      rd(6'h20, r); chk("R7 period hi", r, ~p);
      rd(6'h08, r); chk("R9 event lo", r, p + 7);
      rd(6'h0C, r); chk("R9 event hi", r, p - 3);
    end
    // R3 R6 R2: immediate loads near the carry boundary
    for (int h = 0; h < 3; h++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] e = {32'h0000_0100 * h + 32'd5, 32'hFFFF_FFFF - 32'(k)};
        set_time(e, 32'h1);
        base = e; bc = last_t;
        chk_now("R3 R6 coherent load");
        repeat (k) @(negedge clk);
        chk_now("R2 R6 counting");
      end
    end
    // R5 R10 snapshots with varied hold
    for (int k = 1; k < 5; k++) begin
      pulse(k * 5);
      sn = exp_at(tp + 2);
      chk_snap("R5 R10 snapshot", sn);
      repeat (10) @(negedge clk);
      chk_snap("R10 held snapshot", sn);
      chk_now("R5 no load");
    end
    // R4 armed load
    set_time(64'hABCD_0000_0000_0010, 32'h2);
    rd(6'h10, r); chk("R4 armed bit", r, 32'h2);
    chk_now("R4 not loaded yet");
    pulse(3);
    base = 64'hABCD_0000_0000_0010; bc = tp + 2;
    chk_now("R4 loaded at pps");
    rd(6'h10, r); chk("R4 arm cleared", r, 0);
    pulse(3);
    chk_now("R4 second pps no load");
    chk_snap("R4 R5 snapshot", exp_at(tp + 2));
    // R8 both bits
    set_time(64'h0000_0042_FFFF_FF00, 32'h3);
    base = 64'h0000_0042_FFFF_FF00; bc = last_t;
    rd(6'h10, r); chk("R8 arm discarded", r, 0);
    chk_now("R8 immediate load");
    pulse(2);
    chk_now("R8 pps no reload");
    // R4 arm then immediate load cancels
    set_time(64'h5, 32'h2);
    wr(6'h10, 32'h1);
    base = 64'h5; bc = last_t;
    rd(6'h10, r); chk("R4 arm cancelled by load", r, 0);
    pulse(2);
    chk_now("R4 cancelled arm no reload");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule